// File: doc/BRIEF.md
# Buffered A/D Trigger Scheduler

This block issues start requests to an A/D converter from the count of an up/down timer. Software loads a cycle-set value into a buffer register. At selected turning points of the count waveform (the crest, the trough, or both) the buffer is copied into an active cycle-set register. The block watches the counter. When the counter equals the active value and the counting direction is one that has been enabled, it raises a one-clock trigger pulse.

The trigger can be tied to an interrupt-skipping counter. That counter counts timer events, and the operating mode chooses which event is counted. When the trigger is linked, it is allowed only in the interval that opens at the event where the skip count is reached. When skipping is switched off, a linked trigger never fires. The timer itself, the PWM output stage and the converter sit outside the block.

Top module: `adc_trig_sched`

## Requirements
- R1: The mode input is encoded 00 normal, 01 PWM mode 1, 10 reset-synchronized PWM and 11 complementary PWM. In complementary PWM mode, control bits [1:0] set the transfer timing:
  - 00: the buffer is never copied.
  - 01: the buffer is copied into the active register on a clock where `crest` is high.
  - 10: it is copied on a clock where `trough` is high.
  - 11: it is copied on either strobe.
- R2: In any mode other than complementary PWM, the transfer timing acts as 00, so crest and trough leave the active register unchanged. In those modes, `cfg_illegal` is high combinationally whenever control bits [1:0] are non-zero.
- R3: A buffer write and a transfer can land in the same clock. In that case the active register takes the buffer value from before the write, and the new value waits for the next transfer point.
- R4: `trig` is a single-cycle pulse. It goes high one clock after a cycle in which `cnt` equals the active value and the direction is enabled. Control bit 2 enables up-counting (`cnt_dn`=0) and bit 3 enables down-counting (`cnt_dn`=1). No further pulse is issued while the condition stays true on consecutive clocks.
- R5: The skip counter counts `crest` in complementary PWM mode, `cmp3a_match` in reset-synchronized PWM mode, and `cmp4a_match` in normal and PWM mode 1 modes.
- R6: Control bit 4 is the link enable, and control bits [15:6] hold the skip count N.
  - With link enable at 0, the trigger is independent of skipping.
  - With link enable at 1, a trigger is allowed only after the N-th counted event, and only until the next counted event. On all other events the trigger is held off.
- R7: Control bit 5 enables skipping. If link enable is 1 while skipping is disabled (bit 5 at 0, or N equal to 0), no trigger is ever issued.
- R8: The control register (`wr_sel`=0) changes only on a write with both byte enables set; any other write leaves it unchanged. The buffer (`wr_sel`=1) is written byte by byte under `wr_be`.
- R9: A synchronous reset clears the control register, the buffer, the active register and the skip state to zero, and holds `trig` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control register, 1 selects buffer |
| wr_be | input | 2 | Byte enables, bit 0 for bits [7:0] |
| wr_data | input | 16 | Write data |
| mode | input | 2 | Timer operating mode |
| cnt | input | 16 | Timer counter value |
| cnt_dn | input | 1 | 1 while counting down |
| crest | input | 1 | Counter at its crest this clock |
| trough | input | 1 | Counter at its trough this clock |
| cmp3a_match | input | 1 | Channel-3 counter matches its compare register A |
| cmp4a_match | input | 1 | Channel-4 counter matches its compare register A |
| trig | output | 1 | A/D start request pulse |
| cfg_illegal | output | 1 | Non-zero transfer timing outside complementary PWM mode |

## Verification
Two pairs of functions can meet in the same clock.

The first pair is a buffer write and a crest transfer. The bench drives a full buffer write in the same cycle as a crest strobe. It then uses compare probes to judge that the active register holds the older value, and that the newer value appears only after a second crest.

The second pair is a counted skip event and the compare. The bench probes the counter after each counted event to show where the linked trigger window opens and closes. It also probes after each event that the current mode does not count, to show that those events leave the window unchanged.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int DW     = 16;
    localparam int NBYTE  = DW / 8;
    localparam int SKIP_W = DW - 6;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PWM1   = 2'b01,
        MODE_RSYNC  = 2'b10,
        MODE_COMPL  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'b00,
        XFER_CREST  = 2'b01,
        XFER_TROUGH = 2'b10,
        XFER_BOTH   = 2'b11
    } xfer_e;

    typedef struct packed {
        logic [SKIP_W-1:0] skip_n;
        logic              skip_en;
        logic              link;
        logic              dn_en;
        logic              up_en;
        xfer_e             xfer;
    } ctrl_t;

    function automatic xfer_e eff_xfer(mode_e m, xfer_e x);
        return (m == MODE_COMPL) ? x : XFER_NONE;
    endfunction
endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
    import adc_trig_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [NBYTE-1:0]    wr_be,
    input  logic [DW-1:0]       wr_data,
    input  mode_e               mode,
    input  logic                crest,
    input  logic                trough,
    output ctrl_t               ctrl,
    output logic [DW-1:0]       active,
    output logic                cfg_illegal
);
    logic [7:0]    buf_b [NBYTE];
    logic [DW-1:0] buf_w;
    xfer_e         xe;
    logic          xfer_now;

    always_comb begin
        for (int i = 0; i < NBYTE; i++) buf_w[i*8 +: 8] = buf_b[i];
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                buf_b[b] <= '0;
            else if (wr_en && wr_sel && wr_be[b])
                buf_b[b] <= wr_data[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_en && !wr_sel && (&wr_be))
            ctrl <= ctrl_t'(wr_data);
    end

    always_comb begin
        xe       = eff_xfer(mode, ctrl.xfer);
        xfer_now = (crest && xe[0]) || (trough && xe[1]);
    end

    assign cfg_illegal = (mode != MODE_COMPL) && (ctrl.xfer != XFER_NONE);

    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (xfer_now)
            active <= buf_w;
    end

    // R2
    no_xfer_outside_compl_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_COMPL) |=> $stable(active));
    // R8
    ctrl_word_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !(&wr_be)) |=> $stable(ctrl));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (active == '0 && ctrl == '0));
endmodule

// File: rtl/adc_trig_skip.sv
module adc_trig_skip
    import adc_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              crest,
    input  logic              cmp3a_match,
    input  logic              cmp4a_match,
    input  logic              skip_en,
    input  logic [SKIP_W-1:0] skip_n,
    output logic              skip_on,
    output logic              pass
);
    logic              evt;
    logic [SKIP_W-1:0] cnt_q;

    always_comb begin
        unique case (mode)
            MODE_COMPL: evt = crest;
            MODE_RSYNC: evt = cmp3a_match;
            default:    evt = cmp4a_match;
        endcase
    end

    assign skip_on = skip_en && (skip_n != '0);

    always_ff @(posedge clk) begin
        if (rst || !skip_on) begin
            cnt_q <= '0;
            pass  <= 1'b0;
        end else if (evt) begin
            if (cnt_q >= skip_n - SKIP_W'(1)) begin
                cnt_q <= '0;
                pass  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + SKIP_W'(1);
                pass  <= 1'b0;
            end
        end
    end

    // R6
    pass_opens_on_event_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pass) |-> $past(evt));
    // R7
    pass_closed_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !skip_on |=> !pass);
endmodule

// File: rtl/adc_trig_cmp.sv
module adc_trig_cmp
    import adc_trig_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] cnt,
    input  logic          cnt_dn,
    input  logic [DW-1:0] active,
    input  logic          up_en,
    input  logic          dn_en,
    input  logic          gate,
    output logic          trig
);
    logic hit;
    logic hit_q;

    assign hit = (cnt == active) && (cnt_dn ? dn_en : up_en) && gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            trig  <= 1'b0;
        end else begin
            hit_q <= hit;
            trig  <= hit && !hit_q;
        end
    end

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
endmodule

// File: rtl/adc_trig_sched.sv
module adc_trig_sched
    import adc_trig_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [1:0]    wr_be,
    input  logic [15:0]   wr_data,
    input  logic [1:0]    mode,
    input  logic [15:0]   cnt,
    input  logic          cnt_dn,
    input  logic          crest,
    input  logic          trough,
    input  logic          cmp3a_match,
    input  logic          cmp4a_match,
    output logic          trig,
    output logic          cfg_illegal
);
    ctrl_t         ctrl;
    logic [DW-1:0] active;
    logic          skip_on;
    logic          pass;
    logic          gate;
    mode_e         mode_m;

    assign mode_m = mode_e'(mode);

    adc_trig_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .mode(mode_m), .crest(crest), .trough(trough),
        .ctrl(ctrl), .active(active), .cfg_illegal(cfg_illegal)
    );

    adc_trig_skip u_skip (
        .clk(clk), .rst(rst), .mode(mode_m), .crest(crest),
        .cmp3a_match(cmp3a_match), .cmp4a_match(cmp4a_match),
        .skip_en(ctrl.skip_en), .skip_n(ctrl.skip_n),
        .skip_on(skip_on), .pass(pass)
    );

    assign gate = !ctrl.link || (pass && skip_on);

    adc_trig_cmp u_cmp (
        .clk(clk), .rst(rst), .cnt(cnt), .cnt_dn(cnt_dn), .active(active),
        .up_en(ctrl.up_en), .dn_en(ctrl.dn_en), .gate(gate), .trig(trig)
    );

    // R7
    linked_off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.link && !skip_on) |=> !trig);
endmodule

// File: tb/adc_trig_sched_bench.sv
module adc_trig_sched_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] cnt = 16'hFFFF;
    logic        cnt_dn = 1'b0, crest = 1'b0, trough = 1'b0;
    logic        cmp3a_match = 1'b0, cmp4a_match = 1'b0;
    logic        trig, cfg_illegal;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    adc_trig_sched u_adc_trig_sched (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .mode(mode), .cnt(cnt), .cnt_dn(cnt_dn),
        .crest(crest), .trough(trough), .cmp3a_match(cmp3a_match),
        .cmp4a_match(cmp4a_match), .trig(trig), .cfg_illegal(cfg_illegal)
    );

    // {cnt_dn, expected trig, cnt}; active = 100, only up-count enabled
    localparam logic [17:0] VEC [0:6] = '{
        {1'b0, 1'b0, 16'd99},  {1'b0, 1'b1, 16'd100}, {1'b0, 1'b0, 16'd101},
        {1'b1, 1'b0, 16'd100}, {1'b0, 1'b1, 16'd100}, {1'b0, 1'b0, 16'd100},
        {1'b1, 1'b0, 16'd99}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic probe(input string tag, input logic [15:0] v, input logic dn,
                         input logic exp);
        cnt = v; cnt_dn = dn;
        tick();
        check(tag, trig, exp);
        cnt = 16'hFFFF; cnt_dn = 1'b0;
        tick();
    endtask

    task automatic pulse_crest();  crest = 1'b1;  tick(); crest = 1'b0;  endtask
    task automatic pulse_trough(); trough = 1'b1; tick(); trough = 1'b0; endtask
    task automatic pulse_c3();     cmp3a_match = 1'b1; tick(); cmp3a_match = 1'b0; endtask
    task automatic pulse_c4();     cmp4a_match = 1'b1; tick(); cmp4a_match = 1'b0; endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        check("R9 trig after reset", trig, 1'b0);
        check("R9 cfg_illegal after reset", cfg_illegal, 1'b0);
        mode = 2'b11;
        wr(1'b0, 2'b11, 16'h0004);
        probe("R9 active cleared", 16'd0, 1'b0, 1'b1);

        // load 100 at crest, then walk the vector table
        wr(1'b1, 2'b11, 16'd100);
        wr(1'b0, 2'b11, 16'h0005);
        pulse_crest();
        for (int i = 0; i < 7; i++) begin
            cnt_dn = VEC[i][17]; cnt = VEC[i][15:0];
            tick();
            check($sformatf("R4 vector %0d", i), trig, VEC[i][16]);
        end
        cnt = 16'hFFFF; cnt_dn = 1'b0; tick();

        // trough-only timing, both directions enabled
        wr(1'b0, 2'b11, 16'h000E);
        wr(1'b1, 2'b11, 16'd200);
        pulse_crest();
        probe("R1 trough mode ignores crest new", 16'd200, 1'b0, 1'b0);
        probe("R1 trough mode ignores crest old", 16'd100, 1'b0, 1'b1);
        pulse_trough();
        probe("R1 trough transfer", 16'd200, 1'b0, 1'b1);
        probe("R4 down-count enabled", 16'd200, 1'b1, 1'b1);

        // both strobes
        wr(1'b0, 2'b11, 16'h000F);
        wr(1'b1, 2'b11, 16'd300);
        pulse_trough();
        probe("R1 both at trough", 16'd300, 1'b0, 1'b1);
        wr(1'b1, 2'b11, 16'd400);
        pulse_crest();
        probe("R1 both at crest", 16'd400, 1'b0, 1'b1);

        // outside complementary mode
        mode = 2'b00; #1;
        check("R2 illegal flagged", cfg_illegal, 1'b1);
        wr(1'b1, 2'b11, 16'd500);
        pulse_crest();
        pulse_trough();
        probe("R2 no transfer new", 16'd500, 1'b0, 1'b0);
        probe("R2 no transfer old", 16'd400, 1'b0, 1'b1);
        mode = 2'b11; #1;
        check("R2 legal in compl", cfg_illegal, 1'b0);

        // byte writes
        wr(1'b1, 2'b01, 16'h12AB);
        wr(1'b0, 2'b01, 16'h0000);
        pulse_crest();
        probe("R8 byte buffer and ctrl kept", 16'h01AB, 1'b0, 1'b1);

        // buffer write colliding with transfer
        wr(1'b0, 2'b11, 16'h000D);
        wr(1'b1, 2'b11, 16'd600);
        pulse_crest();
        wr_en = 1'b1; wr_sel = 1'b1; wr_be = 2'b11; wr_data = 16'd700; crest = 1'b1;
        tick();
        wr_en = 1'b0; crest = 1'b0;
        probe("R3 old value copied", 16'd600, 1'b0, 1'b1);
        probe("R3 new value waits", 16'd700, 1'b0, 1'b0);
        pulse_crest();
        probe("R3 new value next crest", 16'd700, 1'b0, 1'b1);

        // linked with skipping off
        wr(1'b0, 2'b11, 16'h0014);
        probe("R7 link skip disabled", 16'd700, 1'b0, 1'b0);
        wr(1'b0, 2'b11, 16'h0034);
        pulse_crest(); pulse_crest();
        probe("R7 link skip count zero", 16'd700, 1'b0, 1'b0);

        // linked, N = 2, complementary mode counts crest
        wr(1'b0, 2'b11, 16'h00B4);
        probe("R6 before events", 16'd700, 1'b0, 1'b0);
        pulse_crest();
        probe("R6 skipped event", 16'd700, 1'b0, 1'b0);
        pulse_crest();
        probe("R6 count reached", 16'd700, 1'b0, 1'b1);
        probe("R6 window still open", 16'd700, 1'b0, 1'b1);
        pulse_crest();
        probe("R6 window closed", 16'd700, 1'b0, 1'b0);
        wr(1'b0, 2'b11, 16'h00A4);
        probe("R6 unlinked independent", 16'd700, 1'b0, 1'b1);

        // reset-synchronized mode counts channel-3 match
        wr(1'b0, 2'b11, 16'h0004);
        mode = 2'b10;
        wr(1'b0, 2'b11, 16'h00B4);
        pulse_c4(); pulse_c4();
        probe("R5 rsync ignores ch4", 16'd700, 1'b0, 1'b0);
        pulse_c3(); pulse_c3();
        probe("R5 rsync counts ch3", 16'd700, 1'b0, 1'b1);

        // normal mode counts channel-4 match
        wr(1'b0, 2'b11, 16'h0004);
        mode = 2'b00;
        wr(1'b0, 2'b11, 16'h00B4);
        pulse_c3(); pulse_c3(); pulse_crest(); pulse_crest();
        probe("R5 normal ignores ch3 and crest", 16'd700, 1'b0, 1'b0);
        pulse_c4(); pulse_c4();
        probe("R5 normal counts ch4", 16'd700, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule